// File: doc/BRIEF.md
# Sensorless Six-State Commutation Sequencer

This block steps a three-phase half-bridge through the six electrical states of a brushless motor. It outputs high-side and low-side gate enables for phases A, B and C. It reads one digitized comparator bit, which reports whether the undriven phase is above the motor centre tap. All timing that a sensorless controller usually takes from capacitors comes instead from clock-cycle counters with programmable lengths:

- a blanking window after each state change;
- a watchdog that forces a step when no crossing arrives;
- a fixed-period stepping timer for step mode;
- an adaptive delay from each accepted zero crossing to the next commutation.

When a crossing of the correct polarity is accepted, the block does three things. It toggles a crossing flag. It loads the length of the interval just measured, which excludes blanking cycles. It then counts that value down by two per cycle, so the commutation lands at roughly half the interval after the crossing. Direction, braking, step mode and sleep are plain level inputs.

Top module: `commutation_sequencer`

## Requirements

The state encoding and the phase bit order used throughout are as follows. `phase_state` carries the state number 1 to 6. Bit 0 of `hs_en` and `ls_en` is phase A, bit 1 is phase B and bit 2 is phase C.

- R1: While `rst_n` is low, or while `run` is low, all six gate enables are 0. While `rst_n` is low, `fcom` is 0. One clock edge after `run` falls, `phase_state` reads 1.
- R2: With `run` high and no brake, each state drives one high side (H) and one low side (L), and leaves the third phase off (Z). Written as (A,B,C), the states are:
  - 1 = (H,Z,L)
  - 2 = (H,L,Z)
  - 3 = (Z,L,H)
  - 4 = (L,Z,H)
  - 5 = (L,H,Z)
  - 6 = (Z,H,L)
- R3: When `run` rises, the sequencer starts in state 1.
- R4: With `dir`=0 the states advance 1,2,3,4,5,6,1. With `dir`=1 they advance 1,6,5,4,3,2,1.
- R5: A crossing is accepted only when `zc_in` equals the expected level. With `dir`=0 the expected level is 1 in even states and 0 in odd states. `dir`=1 inverts it. A wrong level is never accepted.
- R6: After each state change, `zc_in` is ignored for ceil(`blank_len`/(`blank_sel`+1)) cycles.
- R7: If no crossing has been accepted in a state, the sequencer leaves that state after exactly `wd_len` cycles.
- R8: `fcom` toggles once for each accepted crossing, at most once per state. The change appears one clock edge after the cycle in which the crossing is accepted.
- R9: Let N be the number of non-blanking cycles from the previous accepted crossing (or from `run` rising) up to the current accepted crossing. The next commutation comes max(1, ceil(N/2)) cycles after the current crossing.
- R10: With `step_mode` high, `zc_in` is ignored, `fcom` holds, and each state lasts exactly `step_len` cycles.
- R11: With `run` high and either `brake_pin` or `brake_bit` high, `hs_en`=000 and `ls_en`=111 in the same cycle. The state table returns as soon as both brake inputs are low.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | 1 = run, 0 = sleep |
| dir | input | 1 | 0 = forward, 1 = reverse |
| step_mode | input | 1 | Step with the timer only |
| brake_pin | input | 1 | Brake request from a pin |
| brake_bit | input | 1 | Brake request from a register |
| blank_sel | input | 2 | Blanking rate select; rate = value + 1 |
| blank_len | input | CW | Blanking length at rate 1, in cycles |
| wd_len | input | CW | Watchdog period, in cycles |
| step_len | input | CW | State length in step mode, in cycles |
| zc_in | input | 1 | Comparator: 1 = floating phase above centre tap |
| hs_en | output | 3 | High-side enables {C,B,A} |
| ls_en | output | 3 | Low-side enables {C,B,A} |
| phase_state | output | 3 | Current state number, 1..6 |
| fcom | output | 1 | Toggles on each accepted crossing |

## Verification

The gate enables are combinational from the state register, `run` and the brake inputs. The bench therefore checks brake and sleep effects on the falling edge right after it drives them. `phase_state` and `fcom` change one rising edge after the deciding cycle. Counting from the falling edge on which `run` or a new state first appears (cycle 0):

- a watchdog or step-mode state change is seen exactly `wd_len` or `step_len` falling edges later;
- a crossing accepted at cycle B shows on `fcom` at falling edge B+1;
- the commutation that follows shows j falling edges after that, where j is the R9 delay.

The bench tracks the state age itself at each falling edge. It counts edges to each observed change and compares the count with a value worked out from the requirements, never with a count read from the design.

// File: rtl/commutation_sequencer.sv
module commutation_sequencer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          dir,
  input  logic          step_mode,
  input  logic          brake_pin,
  input  logic          brake_bit,
  input  logic [1:0]    blank_sel,
  input  logic [CW-1:0] blank_len,
  input  logic [CW-1:0] wd_len,
  input  logic [CW-1:0] step_len,
  input  logic          zc_in,
  output logic [2:0]    hs_en,
  output logic [2:0]    ls_en,
  output logic [2:0]    phase_state,
  output logic          fcom
);

  logic [2:0]    st;
  logic [CW-1:0] age, bacc, icnt, dly;
  logic          seen, pend;

  wire          on      = run & rst_n;
  wire          blank   = bacc < blank_len;
  wire [2:0]    rate    = {1'b0, blank_sel} + 3'd1;
  wire [CW:0]   bsum    = {1'b0, bacc} + {{(CW-2){1'b0}}, rate};
  wire [CW:0]   age1    = {1'b0, age} + {{CW{1'b0}}, 1'b1};
  wire          want_hi = ~st[0] ^ dir;

  wire zc_ok    = on & ~step_mode & ~blank & ~seen & (zc_in == want_hi);
  wire wd_fire  = on & ~step_mode & ~seen & (age1 >= {1'b0, wd_len});
  wire dly_fire = on & ~step_mode & pend & (dly <= CW'(2));
  wire stp_fire = on & step_mode & (age1 >= {1'b0, step_len});
  wire comm     = wd_fire | dly_fire | stp_fire;

  wire [2:0] nxt = dir ? ((st == 3'd1) ? 3'd6 : st - 3'd1)
                       : ((st == 3'd6) ? 3'd1 : st + 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= 3'd1; age <= '0; bacc <= '0; icnt <= '0; dly <= '0;
      seen <= 1'b0; pend <= 1'b0; fcom <= 1'b0;
    end else if (!run) begin
      st <= 3'd1; age <= '0; bacc <= '0; icnt <= '0; dly <= '0;
      seen <= 1'b0; pend <= 1'b0;
    end else begin
      if (comm) begin
        st <= nxt; age <= '0; bacc <= '0; seen <= 1'b0; pend <= 1'b0;
      end else begin
        if (!(&age)) age <= age1[CW-1:0];
        if (blank) bacc <= bsum[CW] ? '1 : bsum[CW-1:0];
        if (pend) dly <= (dly > CW'(2)) ? dly - CW'(2) : '0;
        if (zc_ok) seen <= 1'b1;
      end
      if (zc_ok) begin
        fcom <= ~fcom;
        icnt <= '0;
        if (!comm) begin
          dly  <= icnt;
          pend <= 1'b1;
        end
      end else if (!blank && !step_mode && !(&icnt)) begin
        icnt <= icnt + 1'b1;
      end
    end
  end

  logic [2:0] hs_tab, ls_tab;
  always_comb begin
    case (st)
      3'd1:    begin hs_tab = 3'b001; ls_tab = 3'b100; end
      3'd2:    begin hs_tab = 3'b001; ls_tab = 3'b010; end
      3'd3:    begin hs_tab = 3'b100; ls_tab = 3'b010; end
      3'd4:    begin hs_tab = 3'b100; ls_tab = 3'b001; end
      3'd5:    begin hs_tab = 3'b010; ls_tab = 3'b001; end
      3'd6:    begin hs_tab = 3'b010; ls_tab = 3'b100; end
      default: begin hs_tab = 3'b000; ls_tab = 3'b000; end
    endcase
  end

  assign hs_en       = !on ? 3'b000 : (brake_pin | brake_bit) ? 3'b000 : hs_tab;
  assign ls_en       = !on ? 3'b000 : (brake_pin | brake_bit) ? 3'b111 : ls_tab;
  assign phase_state = st;

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (st >= 3'd1) && (st <= 3'd6)); // R2
  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !brake_pin && !brake_bit) |->
      ($countones(hs_en) == 1 && $countones(ls_en) == 1 && (hs_en & ls_en) == 3'b000)); // R2
  AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(run)) |-> st == 3'd1); // R3
  AST_FCOM_UNBLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fcom) |-> !$past(blank)); // R6
  AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !step_mode && $past(run) && !$past(step_mode) && !seen && wd_len != '0) |-> age < wd_len); // R7
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step_mode) && $past(run)) |-> $stable(fcom)); // R10

endmodule

// File: tb/sim_commutation_sequencer.sv
module sim_commutation_sequencer;
  localparam int CLK_P = 10;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, dir = 1'b0, step_mode = 1'b0;
  logic brake_pin = 1'b0, brake_bit = 1'b0, zc_in = 1'b0;
  logic [1:0] blank_sel = 2'd0;
  logic [CW-1:0] blank_len = 16'd12, wd_len = 16'd40, step_len = 16'd20;
  logic [2:0] hs_en, ls_en, phase_state;
  logic fcom;

  int errors = 0, checks = 0;
  int zmode = 0, cross_t = 0, tb_t = 0;
  logic [2:0] last_st = 3'd1;
  logic last_f = 1'b0, st_chg = 1'b0, f_chg = 1'b0;

  commutation_sequencer #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .dir(dir), .step_mode(step_mode),
    .brake_pin(brake_pin), .brake_bit(brake_bit), .blank_sel(blank_sel),
    .blank_len(blank_len), .wd_len(wd_len), .step_len(step_len), .zc_in(zc_in),
    .hs_en(hs_en), .ls_en(ls_en), .phase_state(phase_state), .fcom(fcom));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] tab(input logic [2:0] s);
    case (s)
      3'd1: return {3'b001, 3'b100};
      3'd2: return {3'b001, 3'b010};
      3'd3: return {3'b100, 3'b010};
      3'd4: return {3'b100, 3'b001};
      3'd5: return {3'b010, 3'b001};
      3'd6: return {3'b010, 3'b100};
      default: return 6'b0;
    endcase
  endfunction

  task automatic tick();
    logic hi;
    @(negedge clk);
    st_chg = (phase_state != last_st);
    f_chg  = (fcom != last_f);
    last_st = phase_state;
    last_f  = fcom;
    if (st_chg) tb_t = 0; else tb_t++;
    hi = ~phase_state[0] ^ dir;
    case (zmode)
      0: zc_in = ~hi;
      1: zc_in = hi;
      default: zc_in = (tb_t >= cross_t) ? hi : ~hi;
    endcase
  endtask

  task automatic start_run();
    tick();
    run = 1'b1;
    tb_t = 0;
    zc_in = (zmode == 1) ? ~phase_state[0] ^ dir : phase_state[0] ^ dir;
  endtask

  task automatic do_reset();
    run = 1'b0; rst_n = 1'b0; step_mode = 1'b0; brake_pin = 1'b0; brake_bit = 1'b0;
    repeat (3) tick();
    chk(hs_en == 3'b000 && ls_en == 3'b000, "R1 reset enables", {hs_en, ls_en}, 0);
    chk(fcom == 1'b0, "R1 reset fcom", fcom, 0);
    rst_n = 1'b1;
    tick();
    last_st = phase_state;
    last_f = fcom;
  endtask

  task automatic t_watchdog(input logic d);
    int cnt;
    logic [2:0] exp_s;
    do_reset();
    dir = d; zmode = 0; blank_sel = 2'd0;
    start_run();
    tick();
    chk(phase_state == 3'd1, "R3 start state", phase_state, 1);
    cnt = 1;
    exp_s = 3'd1;
    for (int k = 0; k < 7; k++) begin
      while (!st_chg) begin
        chk(!f_chg, "R5 wrong level rejected", fcom, last_f);
        tick(); cnt++;
      end
      exp_s = d ? ((exp_s == 3'd1) ? 3'd6 : exp_s - 3'd1) : ((exp_s == 3'd6) ? 3'd1 : exp_s + 3'd1);
      chk(cnt == 40, "R7 watchdog dwell", cnt, 40);
      chk(phase_state == exp_s, d ? "R4 reverse order" : "R4 forward order", phase_state, exp_s);
      chk({hs_en, ls_en} == tab(exp_s), "R2 state table", {hs_en, ls_en}, tab(exp_s));
      tick(); cnt = 1;
    end
  endtask

  task automatic t_blank(input logic [1:0] sel, input int b);
    int cnt;
    do_reset();
    dir = 1'b0; zmode = 1; blank_sel = sel;
    start_run();
    cnt = 0;
    do begin tick(); cnt++; end while (!f_chg && cnt < 60);
    chk(cnt == b + 1, "R6 blanking length", cnt, b + 1);
    chk(f_chg && phase_state == 3'd1, "R8 fcom toggles on crossing", fcom, 1);
    tick();
    chk(st_chg && phase_state == 3'd2, "R9 zero interval gives one cycle", phase_state, 2);
  endtask

  task automatic t_adapt();
    int j, ej, prev, nf;
    do_reset();
    dir = 1'b0; zmode = 2; cross_t = 32; blank_sel = 2'd0;
    start_run();
    prev = 0;
    for (int k = 0; k < 8; k++) begin
      nf = 0;
      do tick(); while (!f_chg);
      ej = (prev + 20 + 1) / 2;
      if (ej < 1) ej = 1;
      j = 0;
      do begin tick(); j++; if (f_chg) nf++; end while (!st_chg && j < 100);
      chk(j == ej, "R9 adaptive delay", j, ej);
      chk(nf == 0, "R8 one toggle per state", nf, 0);
      prev = ej;
    end
  endtask

  task automatic t_step();
    int cnt;
    logic f0;
    do_reset();
    dir = 1'b0; zmode = 1; step_mode = 1'b1;
    f0 = fcom;
    start_run();
    for (int k = 0; k < 6; k++) begin
      cnt = 0;
      do begin tick(); cnt++; end while (!st_chg && cnt < 100);
      chk(cnt == 20, "R10 step period", cnt, 20);
      chk(fcom == f0, "R10 crossings ignored", fcom, f0);
    end
    step_mode = 1'b0;
  endtask

  task automatic t_brake_sleep();
    do_reset();
    dir = 1'b0; zmode = 0;
    start_run();
    repeat (3) tick();
    brake_pin = 1'b1; tick();
    chk(hs_en == 3'b000 && ls_en == 3'b111, "R11 brake pin", {hs_en, ls_en}, 7);
    brake_pin = 1'b0; brake_bit = 1'b1; tick();
    chk(hs_en == 3'b000 && ls_en == 3'b111, "R11 brake bit", {hs_en, ls_en}, 7);
    brake_bit = 1'b0; tick();
    chk({hs_en, ls_en} == tab(phase_state), "R11 brake release", {hs_en, ls_en}, tab(phase_state));
    repeat (50) tick();
    run = 1'b0; tick();
    chk(hs_en == 3'b000 && ls_en == 3'b000, "R1 sleep enables", {hs_en, ls_en}, 0);
    chk(phase_state == 3'd1, "R1 sleep state", phase_state, 1);
    brake_pin = 1'b1; tick();
    chk(hs_en == 3'b000 && ls_en == 3'b000, "R1 sleep beats brake", {hs_en, ls_en}, 0);
    brake_pin = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_watchdog(1'b0);
    t_watchdog(1'b1);
    t_blank(2'd0, 12);
    t_blank(2'd1, 6);
    t_blank(2'd2, 4);
    t_blank(2'd3, 3);
    t_adapt();
    t_step();
    t_brake_sleep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule